// File: doc/BRIEF.md
# Vector Signed Saturating Narrow Unit

This datapath block takes one vector operand and a 3-bit element-size code. It treats the operand as an array of signed two's-complement source elements. Each element is clamped to the signed range of an integer half its width. The clamped value of source element `e` is placed in half-width result lane `2e`, and half-width lane `2e+1` is filled with zeros. In effect, every source element slot keeps its narrowed value in its lower half and has its upper half cleared.

The size code is one-hot and chooses 16-, 32- or 64-bit source elements. Every other code is reported as illegal, and in that case the result is all zeros. The vector width `VLEN` is a parameter and must be a multiple of 64. The unit returns its result exactly one cycle after an input is accepted, whatever the data. A debug vector marks which source elements were clamped. Register file access and opcode decode stay outside the block.

Top module: `vsn_narrow_unit`

## Requirements
- R1: Size code 3'b001 selects 16-bit source elements, 3'b010 selects 32-bit and 3'b100 selects 64-bit. The element count is VLEN divided by that width, and source element e occupies operand bits [e*W +: W].
- R2: Size codes 3'b000, 3'b011, 3'b101, 3'b110 and 3'b111 set out_illegal to 1 and drive out_result and out_sat to all zeros. Legal codes set out_illegal to 0.
- R3: A source value greater than 2^(h-1)-1 (h = W/2) produces exactly 2^(h-1)-1 in its narrowed lane.
- R4: A source value less than -2^(h-1) produces exactly -2^(h-1) in its narrowed lane.
- R5: A source value inside [-2^(h-1), 2^(h-1)-1] appears unchanged, as h-bit two's complement, in its narrowed lane.
- R6: The narrowed value of source element e appears at out_result bits [e*W +: W/2], which is half-width lane 2e.
- R7: Half-width lane 2e+1, out_result bits [e*W + W/2 +: W/2], is zero for every e when the code is legal.
- R8: out_valid is high in the cycle after each cycle where in_valid is high, and low otherwise. Back-to-back inputs each give their own result. The latency never depends on the data.
- R9: out_sat bit e is 1 exactly when source element e was clamped. Bits at or above the element count are 0.
- R10: While in_valid is low, out_result, out_illegal and out_sat hold their previous values.
- R11: After synchronous reset, out_valid, out_illegal, out_result and out_sat are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand and size code are present this cycle |
| in_operand | input | VLEN | Source vector of signed elements |
| in_size | input | 3 | One-hot source element width code |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_result | output | VLEN | Narrowed values in even lanes, zeros in odd lanes |
| out_illegal | output | 1 | The accepted size code was not a legal one |
| out_sat | output | VLEN/16 | One bit per source element that was clamped |

## Verification
The hardest cases to reach are the exact edges of the narrow range: the half-width maximum and minimum themselves, and the values one step beyond them, at every element width. Random operands almost never land on these. The bench therefore builds operands whose elements cycle through a fixed set of edge values: h-bit max, max+1, min, min-1, -1, 0 and the full-width extremes. It rotates that set through the element slots, so every value appears in every lane position, including the 64-bit case where only two elements fit. Back-to-back inputs with alternating size codes check that one result does not leak into the next.

// File: rtl/vsn_pkg.sv
package vsn_pkg;

    // Legal one-hot element width codes
    typedef enum logic [2:0] {
        SZ_HALF16 = 3'b001,
        SZ_WORD32 = 3'b010,
        SZ_DBL64  = 3'b100
    } size_code_e;

    localparam int NUM_WIDTHS   = 3;
    localparam int BASE_SRC_W   = 16;
    localparam int VLEN_GRAIN   = 64;

    // Decoded width selection: legal flag plus one-hot pick per width path
    typedef struct packed {
        logic                  legal;
        logic [NUM_WIDTHS-1:0] pick;
    } size_sel_t;

    function automatic logic code_is_legal(input logic [2:0] code);
        return (code == SZ_HALF16) || (code == SZ_WORD32) || (code == SZ_DBL64);
    endfunction

    function automatic int src_width_of(input int idx);
        return BASE_SRC_W << idx;
    endfunction

endpackage

// File: rtl/vsn_size_decode.sv
module vsn_size_decode
    import vsn_pkg::*;
(
    input  logic [2:0] size_code,
    output size_sel_t  sel
);
    always_comb begin
        sel.legal = code_is_legal(size_code);
        sel.pick  = sel.legal ? size_code : '0;
    end

    // Pick is one-hot exactly when legal, empty otherwise
    always_comb begin
        AST_PICK_ONEHOT: assert (sel.legal ? ($countones(sel.pick) == 1) : (sel.pick == '0)); // R2
    end
endmodule

// File: rtl/vsn_sat_lane.sv
module vsn_sat_lane #(
    parameter int SRC_W = 16
) (
    input  logic [SRC_W-1:0]   src,
    output logic [SRC_W/2-1:0] narrowed,
    output logic               clamped
);
    localparam int HALF = SRC_W / 2;
    localparam logic [HALF-1:0] POS_LIMIT = {1'b0, {(HALF-1){1'b1}}};
    localparam logic [HALF-1:0] NEG_LIMIT = {1'b1, {(HALF-1){1'b0}}};

    logic [HALF:0] upper;   // bits from narrow sign bit to top
    logic          fits;

    always_comb begin
        upper    = src[SRC_W-1:HALF-1];
        fits     = (&upper) | ~(|upper);
        clamped  = ~fits;
        if (fits)
            narrowed = src[HALF-1:0];
        else if (src[SRC_W-1])
            narrowed = NEG_LIMIT;
        else
            narrowed = POS_LIMIT;
    end

    always_comb begin
        if (clamped) begin
            AST_CLAMP_EXTREME: assert (narrowed == POS_LIMIT || narrowed == NEG_LIMIT); // R3
        end
    end
endmodule

// File: rtl/vsn_width_path.sv
module vsn_width_path #(
    parameter int VLEN  = 128,
    parameter int SRC_W = 16
) (
    input  logic [VLEN-1:0]    operand,
    output logic [VLEN-1:0]    packed_res,
    output logic [VLEN/16-1:0] sat_flags
);
    localparam int HALF  = SRC_W / 2;
    localparam int NELEM = VLEN / SRC_W;
    localparam int NSAT  = VLEN / 16;

    for (genvar e = 0; e < NELEM; e++) begin : g_elem
        vsn_sat_lane #(.SRC_W(SRC_W)) u_lane (
            .src      (operand[e*SRC_W +: SRC_W]),
            .narrowed (packed_res[e*SRC_W +: HALF]),
            .clamped  (sat_flags[e])
        );
        assign packed_res[e*SRC_W+HALF +: HALF] = '0;
    end

    if (NSAT > NELEM) begin : g_pad
        assign sat_flags[NSAT-1:NELEM] = '0;
    end
endmodule

// File: rtl/vsn_narrow_unit.sv
module vsn_narrow_unit
    import vsn_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [VLEN-1:0]    in_operand,
    input  logic [2:0]         in_size,
    output logic               out_valid,
    output logic [VLEN-1:0]    out_result,
    output logic               out_illegal,
    output logic [VLEN/16-1:0] out_sat
);
    localparam int NSAT = VLEN / 16;

    initial begin
        AST_VLEN_GRAIN: assert (VLEN % VLEN_GRAIN == 0); // R1
    end

    size_sel_t          sel;
    logic [VLEN-1:0]    path_res [NUM_WIDTHS];
    logic [NSAT-1:0]    path_sat [NUM_WIDTHS];
    logic [VLEN-1:0]    nxt_res;
    logic [NSAT-1:0]    nxt_sat;

    vsn_size_decode u_dec (
        .size_code (in_size),
        .sel       (sel)
    );

    for (genvar gi = 0; gi < NUM_WIDTHS; gi++) begin : g_path
        vsn_width_path #(
            .VLEN  (VLEN),
            .SRC_W (BASE_SRC_W << gi)
        ) u_path (
            .operand    (in_operand),
            .packed_res (path_res[gi]),
            .sat_flags  (path_sat[gi])
        );
    end

    // One-hot merge; an illegal code leaves both vectors at zero
    always_comb begin
        nxt_res = '0;
        nxt_sat = '0;
        for (int gi = 0; gi < NUM_WIDTHS; gi++) begin
            if (sel.pick[gi]) begin
                nxt_res = nxt_res | path_res[gi];
                nxt_sat = nxt_sat | path_sat[gi];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_illegal <= 1'b0;
            out_sat     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= nxt_res;
                out_illegal <= ~sel.legal;
                out_sat     <= nxt_sat;
            end
        end
    end

    function automatic logic [VLEN-1:0] upper_half_mask(input logic [2:0] code);
        logic [VLEN-1:0] m;
        int w;
        m = '0;
        w = (code == SZ_HALF16) ? 16 : (code == SZ_WORD32) ? 32 : 64;
        for (int b = 0; b < VLEN; b++) m[b] = ((b % w) >= (w / 2));
        return m;
    endfunction

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R8
    AST_ILLEGAL_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !$onehot(in_size)) |=> out_illegal); // R2
    AST_LEGAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && $onehot(in_size)) |=> !out_illegal); // R2
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_result == '0 && out_sat == '0)); // R2
    AST_ODD_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal) |-> ((out_result & upper_half_mask($past(in_size))) == '0)); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_illegal) && $stable(out_sat))); // R10
endmodule

// File: tb/test_vsn_narrow_unit.sv
module test_vsn_narrow_unit;
    localparam int CLK_PERIOD = 10;
    localparam int VL = 128;
    localparam int NS = VL / 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [VL-1:0] in_operand;
    logic [2:0]    in_size;
    logic          out_valid;
    logic [VL-1:0] out_result;
    logic          out_illegal;
    logic [NS-1:0] out_sat;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsn_narrow_unit #(.VLEN(VL)) i_vsn_narrow_unit (
        .clk, .rst, .in_valid, .in_operand, .in_size,
        .out_valid, .out_result, .out_illegal, .out_sat
    );

    task automatic check(input string req, input string what,
                         input logic [VL-1:0] act, input logic [VL-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int width_of(input logic [2:0] sz);
        case (sz)
            3'b001: return 16;
            3'b010: return 32;
            3'b100: return 64;
            default: return 0;
        endcase
    endfunction

    // Reference: computed from the requirements on signed integers
    task automatic model(input logic [VL-1:0] op, input logic [2:0] sz,
                         output logic [VL-1:0] res, output logic [NS-1:0] sat,
                         output logic ill);
        int w, h;
        longint v, hi, lo, r;
        res = '0; sat = '0;
        w = width_of(sz);
        ill = (w == 0);
        if (!ill) begin
            h  = w / 2;
            hi = (longint'(1) <<< (h - 1)) - 1;
            lo = -hi - 1;
            for (int e = 0; e < VL / w; e++) begin
                v = 0;
                for (int b = 0; b < 64; b++)
                    v[b] = (b < w) ? op[e*w + b] : op[e*w + w - 1];
                if (v > hi) begin r = hi; sat[e] = 1'b1; end
                else if (v < lo) begin r = lo; sat[e] = 1'b1; end
                else r = v;
                for (int b = 0; b < h; b++) res[e*w + b] = r[b];
            end
        end
    endtask

    task automatic drive(input logic [VL-1:0] op, input logic [2:0] sz);
        @(negedge clk);
        in_valid = 1'b1; in_operand = op; in_size = sz;
    endtask

    task automatic expect_out(input string req, input logic [VL-1:0] op,
                              input logic [2:0] sz);
        logic [VL-1:0] er; logic [NS-1:0] es; logic ei;
        model(op, sz, er, es, ei);
        check("R8", "out_valid", VL'(out_valid), VL'(1));
        check(req, "out_result", out_result, er);
        check(ei ? "R2" : "R9", "out_sat", VL'(out_sat), VL'(es));
        check("R2", "out_illegal", VL'(out_illegal), VL'(ei));
    endtask

    task automatic one_shot(input string req, input logic [VL-1:0] op,
                            input logic [2:0] sz);
        drive(op, sz);
        @(negedge clk);
        in_valid = 1'b0;
        expect_out(req, op, sz);
    endtask

    function automatic logic [VL-1:0] rand_vec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [VL-1:0] edge_vec(input int w, input int rot);
        logic [VL-1:0] v;
        longint hi, pat;
        int h;
        h  = w / 2;
        hi = (longint'(1) <<< (h - 1)) - 1;
        v  = '0;
        for (int e = 0; e < VL / w; e++) begin
            case ((e + rot) % 8)
                0: pat = hi;
                1: pat = hi + 1;
                2: pat = -hi - 1;
                3: pat = -hi - 2;
                4: pat = -1;
                5: pat = 0;
                6: pat = (w == 64) ? 64'h7fff_ffff_ffff_ffff : ((longint'(1) <<< (w - 1)) - 1);
                default: pat = (w == 64) ? 64'h8000_0000_0000_0000 : -(longint'(1) <<< (w - 1));
            endcase
            for (int b = 0; b < w; b++) v[e*w + b] = pat[b];
        end
        return v;
    endfunction

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_operand = '0; in_size = 3'b001;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11", "valid after reset", VL'(out_valid), '0);
        check("R11", "result after reset", out_result, '0);
        check("R11", "illegal after reset", VL'(out_illegal), '0);
        check("R11", "sat after reset", VL'(out_sat), '0);
    endtask

    task automatic t_random_legal();
        logic [2:0] codes [3] = '{3'b001, 3'b010, 3'b100};
        for (int k = 0; k < 12; k++)
            one_shot("R1", rand_vec(), codes[k % 3]);
    endtask

    task automatic t_small_values();
        // Values that fit pass unchanged (R5); placement in even lanes (R6)
        logic [VL-1:0] op;
        op = '0;
        for (int e = 0; e < VL / 16; e++) op[e*16 +: 16] = (e % 2) ? 16'hffc0 + 16'(e) : 16'(e * 3);
        one_shot("R5", op, 3'b001);
        one_shot("R6", op, 3'b010);
        one_shot("R7", op, 3'b100);
    endtask

    task automatic t_edges();
        // R3 and R4: exact limits and one step past them at every width
        for (int rot = 0; rot < 8; rot++) begin
            one_shot("R3", edge_vec(16, rot), 3'b001);
            one_shot("R4", edge_vec(32, rot), 3'b010);
            one_shot("R9", edge_vec(64, rot), 3'b100);
        end
    endtask

    task automatic t_illegal();
        logic [2:0] bad [5] = '{3'b000, 3'b011, 3'b101, 3'b110, 3'b111};
        for (int k = 0; k < 5; k++)
            one_shot("R2", {VL{1'b1}} ^ rand_vec(), bad[k]);
    endtask

    task automatic t_hold();
        logic [VL-1:0] op, er; logic [NS-1:0] es; logic ei;
        op = edge_vec(16, 1);
        one_shot("R10", op, 3'b001);
        model(op, 3'b001, er, es, ei);
        in_operand = rand_vec(); in_size = 3'b111;
        repeat (3) @(negedge clk);
        check("R8", "valid idle", VL'(out_valid), '0);
        check("R10", "result held", out_result, er);
        check("R10", "sat held", VL'(out_sat), VL'(es));
        check("R10", "illegal held", VL'(out_illegal), VL'(ei));
    endtask

    task automatic t_back_to_back();
        logic [VL-1:0] ops [4];
        logic [2:0] szs [4] = '{3'b100, 3'b011, 3'b001, 3'b010};
        for (int k = 0; k < 4; k++) ops[k] = (k % 2) ? edge_vec(32, k) : rand_vec();
        drive(ops[0], szs[0]);
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            expect_out("R8", ops[k-1], szs[k-1]);
            in_operand = ops[k]; in_size = szs[k];
        end
        @(negedge clk);
        in_valid = 1'b0;
        expect_out("R8", ops[3], szs[3]);
        @(negedge clk);
        check("R8", "valid drops", VL'(out_valid), '0);
    endtask

    initial begin
        t_reset();
        t_random_legal();
        t_small_values();
        t_edges();
        t_illegal();
        t_hold();
        t_back_to_back();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule